// File: doc/BRIEF.md
# Dual-Write-Port Program Register File

This block holds the eight 32-bit general registers of a single-cycle processor core. It has two read ports, A and B. Each read port returns the contents of the selected register without waiting for a clock edge. It also has two write ports, which update registers on the rising clock edge:

- The ALU-side port carries execution results.
- The memory-side port carries loaded data.

Both write ports can update different registers at the same edge. An instruction that changes two registers, such as a stack pop that also moves the stack pointer, therefore completes in a single cycle.

Each port is addressed by a 4-bit register ID. ID 4 is the stack pointer by software convention. It is stored like any other register. The ID 0xF is a sentinel that means "no register":

- On a read port, 0xF gives a zero result.
- On a write port, 0xF suppresses the write.

No separate enable wires are needed. Choosing which IDs to present from the instruction fields is left to the surrounding decode logic.

Top module: `prf_dual_wr`

## Requirements
- R1: While rst_ni is low, every register is cleared to zero. After release, all eight IDs read back 0x00000000 on both read ports.
- R2: A read port given an ID from 0 to 7 shows that register's current contents combinationally, in the same cycle the ID is applied.
- R3: A read port given ID 0xF returns 0x00000000.
- R4: A read port given any ID from 0x8 to 0xE returns 0x00000000.
- R5: The ALU-side write port writes its data into the register named by its ID (0 to 7) at the rising clock edge.
- R6: The memory-side write port writes its data into the register named by its ID (0 to 7) at the rising clock edge.
- R7: When both write ports name different registers in one cycle, both registers are updated at the same edge.
- R8: When both write ports name the same register, that register takes the memory-side data.
- R9: A write port given ID 0xF, or any ID from 0x8 to 0xE, changes no register.
- R10: There is no bypass from write to read. In a cycle that writes a register, a read of that register returns the value held before the edge. The new value appears only after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes land on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all registers |
| rd_a_id_i | input | 4 | Read port A register ID (0xF = none) |
| rd_b_id_i | input | 4 | Read port B register ID (0xF = none) |
| wr_alu_id_i | input | 4 | ALU-side write port register ID (0xF = no write) |
| wr_alu_data_i | input | 32 | ALU-side write data |
| wr_mem_id_i | input | 4 | Memory-side write port register ID (0xF = no write) |
| wr_mem_data_i | input | 32 | Memory-side write data |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_data_o | output | 32 | Read port B data |

## Verification
The bench targets these corner cases:

- **Write collision.** Both write ports name one register. A design with the priority reversed would keep the ALU-side value. A design that merges the two data words would show a corrupted value.
- **Read during write.** A register is read in the same cycle it is written. A design with a bypass would show the new data one edge early.
- **Sentinel and out-of-range IDs.** These are applied to both read and write ports while the registers hold non-zero data. A design that truncates the ID to three bits would alias them onto registers 0 to 7, returning stale data or overwriting a live register.
- **Random traffic.** A long stream of random traffic mixes all of these cases and is compared against a behavioural model on every cycle.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int unsigned PRF_DATA_W   = 32;
  localparam int unsigned PRF_ID_W     = 4;
  localparam int unsigned PRF_NUM_REGS = 8;
  localparam logic [PRF_ID_W-1:0] PRF_ID_NONE = '1;
  localparam logic [PRF_ID_W-1:0] PRF_ID_SP   = PRF_ID_W'(4);
endpackage

// File: rtl/prf_wr_dec.sv
module prf_wr_dec #(
  parameter int unsigned ID_W     = prf_pkg::PRF_ID_W,
  parameter int unsigned NUM_REGS = prf_pkg::PRF_NUM_REGS
) (
  input  logic [ID_W-1:0]     id_i,
  output logic [NUM_REGS-1:0] sel_o
);
  // IDs at or above NUM_REGS (incl. the none sentinel) match no entry
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel_o[g] = (id_i == ID_W'(g));
  end
endmodule

// File: rtl/prf_bank.sv
module prf_bank #(
  parameter int unsigned DATA_W   = prf_pkg::PRF_DATA_W,
  parameter int unsigned NUM_REGS = prf_pkg::PRF_NUM_REGS
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_REGS-1:0]              sel_alu_i,
  input  logic [DATA_W-1:0]                data_alu_i,
  input  logic [NUM_REGS-1:0]              sel_mem_i,
  input  logic [DATA_W-1:0]                data_mem_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  q_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_o[g] <= '0;
      end else if (sel_mem_i[g]) begin
        q_o[g] <= data_mem_i;  // memory side wins a collision
      end else if (sel_alu_i[g]) begin
        q_o[g] <= data_alu_i;
      end
    end
  end
endmodule

// File: rtl/prf_rd_port.sv
module prf_rd_port #(
  parameter int unsigned DATA_W   = prf_pkg::PRF_DATA_W,
  parameter int unsigned ID_W     = prf_pkg::PRF_ID_W,
  parameter int unsigned NUM_REGS = prf_pkg::PRF_NUM_REGS
) (
  input  logic [ID_W-1:0]                  id_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  q_i,
  output logic [DATA_W-1:0]                data_o
);
  localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_REGS - 1);

  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (id_i == ID_W'(i)) data_o = q_i[i];
    end
    if (id_i > LAST_ID) data_o = '0;
  end
endmodule

// File: rtl/prf_dual_wr.sv
module prf_dual_wr #(
  parameter int unsigned DATA_W   = prf_pkg::PRF_DATA_W,
  parameter int unsigned ID_W     = prf_pkg::PRF_ID_W,
  parameter int unsigned NUM_REGS = prf_pkg::PRF_NUM_REGS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   rd_a_id_i,
  input  logic [ID_W-1:0]   rd_b_id_i,
  input  logic [ID_W-1:0]   wr_alu_id_i,
  input  logic [DATA_W-1:0] wr_alu_data_i,
  input  logic [ID_W-1:0]   wr_mem_id_i,
  input  logic [DATA_W-1:0] wr_mem_data_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  output logic [DATA_W-1:0] rd_b_data_o
);
  localparam int unsigned NUM_RD = 2;

  logic [NUM_REGS-1:0]             sel_alu, sel_mem;
  logic [NUM_REGS-1:0][DATA_W-1:0] q;
  logic [NUM_RD-1:0][ID_W-1:0]     rd_id;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

  prf_wr_dec #(.ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_dec_alu (
    .id_i(wr_alu_id_i), .sel_o(sel_alu)
  );
  prf_wr_dec #(.ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_dec_mem (
    .id_i(wr_mem_id_i), .sel_o(sel_mem)
  );

  prf_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_alu_i  (sel_alu),
    .data_alu_i (wr_alu_data_i),
    .sel_mem_i  (sel_mem),
    .data_mem_i (wr_mem_data_i),
    .q_o        (q)
  );

  assign rd_id[0] = rd_a_id_i;
  assign rd_id[1] = rd_b_id_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    prf_rd_port #(.DATA_W(DATA_W), .ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_rd (
      .id_i(rd_id[p]), .q_i(q), .data_o(rd_data[p])
    );
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
endmodule

// File: rtl/prf_dual_wr_chk.sv
module prf_dual_wr_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ID_W     = 4,
  parameter int unsigned NUM_REGS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ID_W-1:0]   rd_a_id_i,
  input logic [ID_W-1:0]   rd_b_id_i,
  input logic [ID_W-1:0]   wr_alu_id_i,
  input logic [DATA_W-1:0] wr_alu_data_i,
  input logic [ID_W-1:0]   wr_mem_id_i,
  input logic [DATA_W-1:0] wr_mem_data_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [DATA_W-1:0] rd_b_data_o
);
  localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_REGS - 1);
  localparam logic [ID_W-1:0] NONE_ID = '1;

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (rd_a_data_o == '0 && rd_b_data_o == '0));

  // R3
  rd_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_id_i == NONE_ID) |-> (rd_a_data_o == '0));

  // R4
  rd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_id_i > LAST_ID) |-> (rd_b_data_o == '0));

  // R5
  alu_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_alu_id_i) <= LAST_ID
     && $past(wr_mem_id_i) != $past(wr_alu_id_i)
     && rd_a_id_i == $past(wr_alu_id_i))
    |-> (rd_a_data_o == $past(wr_alu_data_i)));

  // R6
  mem_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_mem_id_i) <= LAST_ID
     && rd_b_id_i == $past(wr_mem_id_i))
    |-> (rd_b_data_o == $past(wr_mem_data_i)));

  // R8
  collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_alu_id_i) <= LAST_ID
     && $past(wr_alu_id_i) == $past(wr_mem_id_i)
     && rd_a_id_i == $past(wr_mem_id_i))
    |-> (rd_a_data_o == $past(wr_mem_data_i)));

  // R9
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_alu_id_i) > LAST_ID
     && $past(wr_mem_id_i) > LAST_ID && $stable(rd_a_id_i))
    |-> $stable(rd_a_data_o));
endmodule

bind prf_dual_wr prf_dual_wr_chk #(
  .DATA_W(DATA_W), .ID_W(ID_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rd_a_id_i     (rd_a_id_i),
  .rd_b_id_i     (rd_b_id_i),
  .wr_alu_id_i   (wr_alu_id_i),
  .wr_alu_data_i (wr_alu_data_i),
  .wr_mem_id_i   (wr_mem_id_i),
  .wr_mem_data_i (wr_mem_data_i),
  .rd_a_data_o   (rd_a_data_o),
  .rd_b_data_o   (rd_b_data_o)
);

// File: tb/prf_dual_wr_test.sv
module prf_dual_wr_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  rd_a_id_i = 4'hF, rd_b_id_i = 4'hF;
  logic [3:0]  wr_alu_id_i = 4'hF, wr_mem_id_i = 4'hF;
  logic [31:0] wr_alu_data_i = '0, wr_mem_data_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o;

  logic [31:0] mdl [8];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  prf_dual_wr uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_a_id_i(rd_a_id_i), .rd_b_id_i(rd_b_id_i),
    .wr_alu_id_i(wr_alu_id_i), .wr_alu_data_i(wr_alu_data_i),
    .wr_mem_id_i(wr_mem_id_i), .wr_mem_data_i(wr_mem_data_i),
    .rd_a_data_o(rd_a_data_o), .rd_b_data_o(rd_b_data_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [31:0] exp_rd(logic [3:0] id);
    return (id < 4'd8) ? mdl[id[2:0]] : 32'h0;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // one cycle: drive at negedge, check pre-edge reads, then model the edge
  task automatic step(string tag, logic [3:0] ra, logic [3:0] rb,
                      logic [3:0] ae, logic [31:0] de,
                      logic [3:0] am, logic [31:0] dm);
    @(negedge clk_i);
    rd_a_id_i = ra; rd_b_id_i = rb;
    wr_alu_id_i = ae; wr_alu_data_i = de;
    wr_mem_id_i = am; wr_mem_data_i = dm;
    #1;
    check(tag, "port A", rd_a_data_o, exp_rd(ra));
    check(tag, "port B", rd_b_data_o, exp_rd(rb));
    @(posedge clk_i);
    if (ae < 4'd8) mdl[ae[2:0]] = de;
    if (am < 4'd8) mdl[am[2:0]] = dm;  // memory side applied last
  endtask

  task automatic idle_read(string tag, logic [3:0] ra, logic [3:0] rb);
    step(tag, ra, rb, 4'hF, 32'hDEAD_0000, 4'hF, 32'hDEAD_1111);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    #23 rst_ni = 1'b1;

    // R1 reset state on every ID
    for (int i = 0; i < 8; i++) idle_read("R1", 4'(i), 4'(7 - i));

    // R5 ALU-side writes, read back next cycle (R2)
    for (int i = 0; i < 8; i++)
      step("R5", 4'(i), 4'hF, 4'(i), 32'hA000_0000 + 32'(i), 4'hF, 32'h0);
    for (int i = 0; i < 8; i++) idle_read("R2", 4'(i), 4'(i));

    // R6 memory-side writes
    for (int i = 0; i < 8; i++)
      step("R6", 4'hF, 4'(i), 4'hF, 32'h0, 4'(i), 32'hB000_0000 + 32'(i));
    for (int i = 0; i < 8; i++) idle_read("R6", 4'(i), 4'(i));

    // R7 both ports, distinct registers
    step("R7", 4'd4, 4'd0, 4'd4, 32'h1234_5678, 4'd0, 32'h8765_4321);
    idle_read("R7", 4'd4, 4'd0);

    // R8 collision: memory side wins
    step("R8", 4'd3, 4'd3, 4'd3, 32'h1111_1111, 4'd3, 32'h2222_2222);
    idle_read("R8", 4'd3, 4'd3);
    step("R8", 4'd6, 4'd6, 4'd6, 32'hFFFF_0000, 4'd6, 32'h0000_FFFF);
    idle_read("R8", 4'd6, 4'd6);

    // R10 read of register being written returns old value (checked pre-edge)
    step("R10", 4'd5, 4'd2, 4'd5, 32'hCAFE_0005, 4'd2, 32'hCAFE_0002);
    idle_read("R10", 4'd5, 4'd2);

    // R9 sentinel and out-of-range write IDs change nothing
    for (int i = 8; i < 16; i++)
      step("R9", 4'(i - 8), 4'(15 - (i - 8)), 4'(i), 32'h5A5A_5A5A, 4'(23 - i), 32'hA5A5_A5A5);
    for (int i = 0; i < 8; i++) idle_read("R9", 4'(i), 4'(i));

    // R3 / R4 zero on sentinel and out-of-range reads with non-zero contents
    idle_read("R3", 4'hF, 4'hF);
    for (int i = 8; i < 15; i++) idle_read("R4", 4'(i), 4'(i));

    // R2 random mixed traffic against the model
    for (int n = 0; n < 3000; n++)
      step("R2", 4'($urandom), 4'($urandom), 4'($urandom), $urandom,
           4'($urandom), $urandom);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule